// File: doc/BRIEF.md
# Converter Command Slave on a Two-Wire Bus

This block is the digital bus front end of a multichannel converter. It watches the two open-drain lines of a two-wire (I2C-compatible) bus with a fast system clock, finds START, repeated START and STOP, and answers when the 7-bit address fixed at build time is sent. A write transaction carries one or more command bytes. The most significant bit of each byte selects its register: 1 stores the byte as the setup byte, 0 stores it as the configuration byte. A read transaction sends bytes taken from a byte input that the converter supplies.

The block also recognises the master code that switches the bus to high-speed timing. It answers that code with a not-acknowledge and raises a mode flag. The flag stays set across repeated STARTs and clears on STOP. The two register values, the mode flag and a strobe for each byte fetched for a read go to the rest of the converter. SDA is driven only as an active-low pull request.

Top module: `adc_i2c_cmd_slave`

## Requirements
- R1: After reset, SDA is released, setup_q is 0x00, config_q is 0x01, hs_mode is 0 and rd_req is 0.
- R2: A START followed by the configured address and a write bit (address byte bit 0 = 0) is acknowledged: the slave pulls SDA low during the ninth clock of that byte.
- R3: A START followed by a different address is not acknowledged, and SDA stays released for the rest of the transaction. Data bytes in that transaction leave both registers unchanged.
- R4: In a write transaction, every data byte is acknowledged. A byte with bit 7 = 1 replaces setup_q and a byte with bit 7 = 0 replaces config_q, whatever the order of the bytes.
- R5: When a setup byte arrives with bit 1 (the reset field) = 0, config_q returns to 0x01 on the same clock that setup_q takes the byte. With bit 1 = 1, config_q is left unchanged.
- R6: An address byte of the form 0000_1xxx is answered with SDA released on the ninth clock. hs_mode becomes 1 after that clock.
- R7: A repeated START followed by an address leaves hs_mode at 1. A STOP clears it.
- R8: For the configured address with the read bit (bit 0 = 1), the slave acknowledges and pulses rd_req once for each byte it takes from rd_byte. It shifts that byte out MSB first, a 0 bit by pulling SDA low. Another byte follows after a master acknowledge, and a master not-acknowledge ends the transfer.
- R9: A STOP arriving partway through a data byte leaves both registers unchanged.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull SDA low |
| rd_byte | input | 8 | Byte to return on a read |
| rd_req | output | 1 | One-cycle strobe when rd_byte is taken |
| setup_q | output | 8 | Stored setup byte |
| config_q | output | 8 | Stored configuration byte |
| hs_mode | output | 1 | 1 = high-speed bus timing selected |

## Verification
A setup byte whose reset field is 0 changes two registers on the same clock: setup_q takes the new byte and config_q returns to its default. The bench provokes this by writing a configuration byte and then, in the same transaction, a setup byte with bit 1 cleared. It also writes a setup byte with the field set, so the no-reset case is covered too. The reference model in the bench updates both expected values at one point, and every clock the bench compares the pair against the design, so a late or missing reset of the configuration shows as a mismatch.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_MNACK
   } bus_state_t;
endpackage

// File: rtl/ai_line_sync.sv
module ai_line_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= raw;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage_q[s] <= '1;
            else        stage_q[s] <= stage_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '1;
      else        prev_q <= stage_q[STAGES-1];

   assign lvl  = stage_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ai_cmd_regs.sv
module ai_cmd_regs #(
   parameter int         BYTE_W      = 8,
   parameter int         RST_BIT     = 1,
   parameter [BYTE_W-1:0] CFG_DEFAULT = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic [BYTE_W-1:0] setup_q,
   output logic [BYTE_W-1:0] config_q
);
   localparam int SEL_BIT = BYTE_W - 1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         setup_q  <= '0;
         config_q <= CFG_DEFAULT;
      end else if (wr_stb) begin
         if (wr_byte[SEL_BIT]) begin
            setup_q <= wr_byte;
            if (!wr_byte[RST_BIT]) config_q <= CFG_DEFAULT;
         end else begin
            config_q <= wr_byte;
         end
      end
endmodule

// File: rtl/ai_bus_fsm.sv
module ai_bus_fsm
   import adc_i2c_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR  = 7'b1100100,
   parameter logic [4:0] MCODE_TAG = 5'b00001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_pull,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              rd_req,
   output logic              hs_mode
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   bus_state_t        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh, tx;
   logic              is_rd, mack;
   logic              start_det, stop_det;

   assign start_det = scl_lvl & sda_fall;
   assign stop_det  = scl_lvl & sda_rise;
   assign wr_byte   = sh;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st <= ST_IDLE;  cnt <= '0;  sh <= '0;  tx <= '0;
         sda_pull <= 1'b0;  hs_mode <= 1'b0;  wr_stb <= 1'b0;
         rd_req <= 1'b0;  is_rd <= 1'b0;  mack <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         rd_req <= 1'b0;
         if (start_det) begin
            st <= ST_ADDR;  cnt <= '0;  sda_pull <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE;  sda_pull <= 1'b0;  hs_mode <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_WDAT: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == LAST) begin
                     if (st == ST_WDAT) begin
                        wr_stb <= 1'b1;  sda_pull <= 1'b1;  st <= ST_WACK;
                     end else if (sh[BYTE_W-1:1] == SLV_ADDR) begin
                        sda_pull <= 1'b1;  is_rd <= sh[0];  st <= ST_AACK;
                     end else if (sh[BYTE_W-1:3] == MCODE_TAG) begin
                        st <= ST_MNACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: if (scl_fall) begin
                  cnt <= '0;
                  if (is_rd) begin
                     tx <= rd_byte;  rd_req <= 1'b1;
                     sda_pull <= ~rd_byte[BYTE_W-1];  st <= ST_RDAT;
                  end else begin
                     sda_pull <= 1'b0;  st <= ST_WDAT;
                  end
               end
               ST_WACK: if (scl_fall) begin
                  sda_pull <= 1'b0;  cnt <= '0;  st <= ST_WDAT;
               end
               ST_RDAT: begin
                  if (scl_rise) cnt <= cnt + 1'b1;
                  else if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_pull <= 1'b0;  st <= ST_RACK;
                     end else begin
                        tx <= {tx[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~tx[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) mack <= ~sda_lvl;
                  else if (scl_fall) begin
                     if (mack) begin
                        tx <= rd_byte;  rd_req <= 1'b1;  cnt <= '0;
                        sda_pull <= ~rd_byte[BYTE_W-1];  st <= ST_RDAT;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_MNACK: if (scl_fall) begin
                  hs_mode <= 1'b1;  st <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
endmodule

// File: rtl/adc_i2c_cmd_slave.sv
module adc_i2c_cmd_slave
   import adc_i2c_pkg::*;
#(
   parameter logic [6:0]        SLV_ADDR    = 7'b1100100,
   parameter int                SYNC_STAGES = 2,
   parameter int                RST_BIT     = 1,
   parameter logic [BYTE_W-1:0] CFG_DEFAULT = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_pull,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              rd_req,
   output logic [BYTE_W-1:0] setup_q,
   output logic [BYTE_W-1:0] config_q,
   output logic              hs_mode
);
   localparam logic [4:0] MCODE_TAG = 5'b00001;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SLV_ADDR[6:2] == MCODE_TAG) begin : g_bad_addr
      $error("SLV_ADDR collides with the high-speed master code");
   end
   if (RST_BIT < 0 || RST_BIT >= BYTE_W - 1) begin : g_bad_rst
      $error("RST_BIT must lie below the register-select bit");
   end

   logic [1:0]        lvl, rise, fall;
   logic              scl_s, sda_s;
   logic              wr_stb;
   logic [BYTE_W-1:0] wr_byte;

   ai_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   assign scl_s = lvl[1];
   assign sda_s = lvl[0];

   ai_bus_fsm #(.SLV_ADDR(SLV_ADDR), .MCODE_TAG(MCODE_TAG)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_s), .scl_rise(rise[1]), .scl_fall(fall[1]),
      .sda_lvl(sda_s), .sda_rise(rise[0]), .sda_fall(fall[0]),
      .rd_byte(rd_byte), .sda_pull(sda_pull), .wr_stb(wr_stb),
      .wr_byte(wr_byte), .rd_req(rd_req), .hs_mode(hs_mode)
   );

   ai_cmd_regs #(.BYTE_W(BYTE_W), .RST_BIT(RST_BIT), .CFG_DEFAULT(CFG_DEFAULT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .setup_q(setup_q), .config_q(config_q)
   );
endmodule

// File: rtl/adc_i2c_cmd_slave_chk.sv
module adc_i2c_cmd_slave_chk #(
   parameter logic [7:0] CFG_DEFAULT = 8'h01,
   parameter int         RST_BIT     = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_s,
   input logic       sda_pull,
   input logic       rd_req,
   input logic       hs_mode,
   input logic [7:0] setup_q,
   input logic [7:0] config_q
);
   // R10
   pull_start_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);

   // R5
   setup_reset_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(setup_q) && !setup_q[RST_BIT]) |-> config_q == CFG_DEFAULT);

   // R4
   setup_change_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(setup_q) |-> sda_pull);

   // R4
   config_change_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(config_q) |-> sda_pull);

   // R7
   hs_clear_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_mode) |-> (scl_s && sda_s));

   // R6
   hs_set_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_mode) |-> !scl_s);

   // R8
   rd_req_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !scl_s);
endmodule

bind adc_i2c_cmd_slave adc_i2c_cmd_slave_chk #(.CFG_DEFAULT(CFG_DEFAULT), .RST_BIT(RST_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_pull(sda_pull),
   .rd_req(rd_req), .hs_mode(hs_mode), .setup_q(setup_q), .config_q(config_q)
);

// File: tb/sim_adc_i2c_cmd_slave.sv
`timescale 1ns/1ps
module sim_adc_i2c_cmd_slave;
   localparam int Q = 10;
   localparam logic [6:0] ADDR = 7'b1100100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic [7:0] rd_byte = 8'h00;
   logic sda_pull, rd_req, hs_mode;
   logic [7:0] setup_q, config_q;
   wire  sda_line = sda_m & ~sda_pull;

   int n_chk = 0, n_fail = 0;
   int rdreq_cnt = 0, r10_bad = 0;
   bit done = 0, mdl_on = 0, prev_pull = 0;
   logic [7:0] m_setup = 8'h00, m_cfg = 8'h01;
   bit m_hs = 0;

   always #10 clk = ~clk;

   adc_i2c_cmd_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
      .rd_byte(rd_byte), .rd_req(rd_req), .setup_q(setup_q), .config_q(config_q),
      .hs_mode(hs_mode)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison with the reference model
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req) rdreq_cnt++;
         if (!prev_pull && sda_pull && scl) r10_bad++;
         prev_pull = sda_pull;
         if (mdl_on) begin
            chk(setup_q == m_setup, "R4/R5 setup model", setup_q, m_setup);
            chk(config_q == m_cfg, "R4/R5 config model", config_q, m_cfg);
            chk(hs_mode == m_hs, "R6/R7 mode model", hs_mode, m_hs);
         end
      end
   end

   task automatic wq(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q);
   endtask

   task automatic bus_stop();
      mdl_on = 0;
      sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q);
      m_hs = 0; wq(5); mdl_on = 1;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
      end
      sda_m = 1; wq(Q); scl = 1; wq(Q); #4; ack = !sda_line; wq(Q); scl = 0; wq(Q);
   endtask

   task automatic wr_data(input logic [7:0] b, output bit ack);
      mdl_on = 0;
      send_byte(b, ack);
      if (b[7]) begin
         m_setup = b;
         if (!b[1]) m_cfg = 8'h01;
      end else m_cfg = b;
      mdl_on = 1;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q); scl = 1; wq(Q); #4; b[i] = sda_line; wq(Q); scl = 0; wq(Q);
      end
      sda_m = !mack; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q); sda_m = 1;
   endtask

   initial begin
      bit ack;
      logic [7:0] rb;
      wq(5);
      #5;
      // R1 reset state
      chk(sda_pull == 0, "R1 sda released", sda_pull, 0);
      chk(setup_q == 8'h00, "R1 setup reset", setup_q, 0);
      chk(config_q == 8'h01, "R1 config reset", config_q, 1);
      chk(hs_mode == 0, "R1 mode reset", hs_mode, 0);
      chk(rd_req == 0, "R1 rd_req idle", rd_req, 0);
      rst_n = 1; wq(5); mdl_on = 1;

      // R2, R4, R5: config then setup with reset field = 1
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
      wr_data(8'h35, ack); chk(ack, "R4 config byte ack", ack, 1);
      wr_data(8'hD6, ack); chk(ack, "R4 setup byte ack", ack, 1);
      chk(config_q == 8'h35, "R5 reset field 1 keeps config", config_q, 8'h35);
      bus_stop();

      // R5: setup with reset field 0, then config (reverse order)
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R2 address ack again", ack, 1);
      wr_data(8'h77, ack);
      wr_data(8'hA4, ack);
      chk(config_q == 8'h01, "R5 config returned to default", config_q, 1);
      chk(setup_q == 8'hA4, "R5 setup written", setup_q, 8'hA4);
      wr_data(8'h12, ack); chk(config_q == 8'h12, "R4 setup then config", config_q, 8'h12);
      bus_stop();

      // R3: wrong address
      bus_start();
      send_byte(8'hCA, ack); chk(!ack, "R3 mismatch not acked", ack, 0);
      send_byte(8'h7F, ack); chk(!ack, "R3 data ignored no ack", ack, 0);
      chk(config_q == 8'h12, "R3 config unchanged", config_q, 8'h12);
      bus_stop();

      // R6, R7: master code, high-speed mode
      bus_start();
      mdl_on = 0;
      send_byte(8'h0D, ack); chk(!ack, "R6 master code nack", ack, 0);
      chk(hs_mode == 1, "R6 mode raised", hs_mode, 1);
      m_hs = 1; mdl_on = 1;
      bus_start();
      send_byte({ADDR, 1'b0}, ack); chk(ack, "R7 address ack in hs", ack, 1);
      wr_data(8'h44, ack);
      bus_start();
      chk(hs_mode == 1, "R7 repeated start keeps mode", hs_mode, 1);
      send_byte({ADDR, 1'b0}, ack);
      bus_stop();
      chk(hs_mode == 0, "R7 stop clears mode", hs_mode, 0);

      // R8: read two bytes
      rd_byte = 8'hA5; rdreq_cnt = 0;
      bus_start();
      send_byte({ADDR, 1'b1}, ack); chk(ack, "R8 read address ack", ack, 1);
      rd_byte = 8'h3C;
      recv_byte(1, rb); chk(rb == 8'hA5, "R8 first read byte", rb, 8'hA5);
      recv_byte(0, rb); chk(rb == 8'h3C, "R8 second read byte", rb, 8'h3C);
      bus_stop();
      chk(rdreq_cnt == 2, "R8 rd_req pulses", rdreq_cnt, 2);

      // R9: STOP inside a data byte
      bus_start();
      send_byte({ADDR, 1'b0}, ack);
      mdl_on = 0;
      for (int i = 0; i < 4; i++) begin
         sda_m = 1; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
      end
      mdl_on = 1;
      bus_stop();
      chk(setup_q == 8'hA4, "R9 setup unchanged", setup_q, 8'hA4);
      chk(config_q == 8'h44, "R9 config unchanged", config_q, 8'h44);

      chk(r10_bad == 0, "R10 pull only with scl low", r10_bad, 0);
      wq(20);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule